// File: doc/BRIEF.md
# Wake and Sleep Start-Up Sequencer

This block decides whether the power-management die is awake or in standby. Four active-low wake lines are ORed. Any line that goes low sets a wake latch, and the latch drives the internal wake signal. The latch also stores which lines caused the wake. The host then acknowledges through a clear input and releases the chip through a sleep input, in that order. The block accepts either handshake only while the reset channel chosen by a sequence-select pin reports its supply good. If no acknowledgement arrives within a programmable number of clock cycles, a watchdog returns the chip to standby. A brown-out pattern on the first reset channel does the same.

Two more outputs follow from the latch state, the internal first-channel reset and the synchronised clear. The first selects the source of the standby supply rail: battery or the first converter output. The second, an enable, makes the low-side clear switch pull its pin low; when the enable is 0 the pin floats. The wake, clear and sleep inputs each pass through a two-flop synchroniser before any use. The block carries no data stream, so it has no valid/ready handshakes; every pin is a plain level.

Top module: `wake_sleep_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, wake_o, sleep_int_o, wake_src_o, stby_vo1_o and sw_oe_o are all 0.
- R2: When any wake_n_i bit is low at a clock edge and wake_o is 0, wake_o is 1 after the third rising edge. wake_src_o has bit i set for each line i that was low, and both hold after the lines return high.
- R3: While wake_o is 1 and no clear has been accepted, wake lines that go low later leave wake_src_o unchanged.
- R4: A clear (clr_i high after synchronisation) is accepted only while the selected external reset is 1. Accepting it sets wake_src_o to 0, keeps wake_o at 1 and stops the watchdog.
- R5: Sleep is qualified when sleep_i is high after synchronisation, the selected external reset is 1 and the synchronised clear is 0. On a rising edge of the qualified sleep while wake_o is 1, wake_o falls and sleep_int_o is 1 for exactly one cycle.
- R6: A qualified sleep rise before any clear has been accepted also drops wake_o and sets wake_src_o to 0.
- R7: If no clear is accepted, wake_o stays 1 for exactly WDT_CYCLES cycles. It then falls together with a one-cycle pulse on sleep_int_o.
- R8: With seq_sel_i = 1 the selected external reset is rst2_ext_i. With seq_sel_i = 0 it is rst1_ext_i.
- R9: stby_vo1_o (1 = first converter output, 0 = battery) equals wake_o AND rst1_int_i. sw_oe_o (1 = switch drives low, 0 = floating) equals wake_o AND rst1_int_i AND the synchronised clear.
- R10: When rst1_int_i is 0 and rst1_ext_i is 1 at a clock edge, sleep_int_o is 1 in the next cycle and wake_o is 0. A wake line is not latched in that cycle.
- R11: A clear accepted in the last cycle of the watchdog window takes priority over expiry: wake_o stays 1 and sleep_int_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_n_i | input | NW | Active-low wake lines, asynchronous |
| clr_i | input | 1 | Host acknowledge, asynchronous |
| sleep_i | input | 1 | Host sleep request, asynchronous |
| seq_sel_i | input | 1 | Reset channel select for completion (1 = channel 2) |
| rst1_int_i | input | 1 | Internal reset status of channel 1 (1 = supply good) |
| rst1_ext_i | input | 1 | External reset output of channel 1 |
| rst2_ext_i | input | 1 | External reset output of channel 2 |
| wake_o | output | 1 | Internal wake |
| sleep_int_o | output | 1 | Internal sleep pulse |
| wake_src_o | output | NW | Lines recorded as wake cause |
| stby_vo1_o | output | 1 | Standby rail source select (1 = converter 1 output) |
| sw_oe_o | output | 1 | Clear switch enable (1 = drive low, 0 = float) |

## Verification
The clear acknowledgement and watchdog expiry can fall in the same cycle. When they do, the clear must win. The bench triggers a wake and waits until wake_o is seen. It then drives the clear so that, after the two synchroniser stages, the clear lands in the last counted cycle of the window. It also runs a variant that is one cycle late. In the first case wake_o must stay 1 with no sleep pulse; in the late case the wake must drop. Long constrained-random runs also mix clear, sleep, brown-out and wake events against a cycle model built from the requirements, so sleep rises and expiries also meet forced sleeps in the same cycle.

// File: rtl/wss_pkg.sv
package wss_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    DROP_NONE  = 2'd0,
    DROP_HOST  = 2'd1,
    DROP_WDT   = 2'd2,
    DROP_FORCE = 2'd3
  } drop_e;
endpackage

// File: rtl/wss_sync.sv
module wss_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wss_gate.sv
module wss_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_s_i,
  input  logic slp_s_i,
  input  logic seq_sel_i,
  input  logic rst1_ext_i,
  input  logic rst2_ext_i,
  output logic clr_ok_o,
  output logic slp_rise_o
);
  logic sel_good;
  logic slp_ok;
  logic slp_prev_q;

  // completion channel chosen by the select pin
  assign sel_good = seq_sel_i ? rst2_ext_i : rst1_ext_i;
  assign clr_ok_o = clr_s_i & sel_good;
  assign slp_ok   = slp_s_i & sel_good & ~clr_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slp_prev_q <= 1'b0;
    else        slp_prev_q <= slp_ok;
  end

  assign slp_rise_o = slp_ok & ~slp_prev_q;
endmodule

// File: rtl/wss_watchdog.sv
module wss_watchdog #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  input  logic ack_i,
  input  logic clr_ok_i,
  input  logic drop_i,
  output logic fire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!wake_i || ack_i || drop_i) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  // an acknowledgement in the final window cycle beats expiry
  assign fire_o = wake_i & ~ack_i & (cnt_q == LAST) & ~clr_ok_i;
endmodule

// File: rtl/wss_wake_latch.sv
module wss_wake_latch
  import wss_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] wake_n_s_i,
  input  logic          clr_ok_i,
  input  logic          slp_rise_i,
  input  logic          wdt_fire_i,
  input  logic          force_i,
  output logic          wake_o,
  output logic          ack_o,
  output logic          drop_o,
  output logic          sleep_o,
  output logic [NW-1:0] src_o
);
  logic          wake_q;
  logic          ack_q;
  logic          sleep_q;
  logic [NW-1:0] src_q;
  logic [NW-1:0] hit;
  drop_e         cause;

  assign hit = ~wake_n_s_i;

  always_comb begin
    if (force_i)                  cause = DROP_FORCE;
    else if (wake_q && wdt_fire_i) cause = DROP_WDT;
    else if (wake_q && slp_rise_i) cause = DROP_HOST;
    else                          cause = DROP_NONE;
  end

  assign drop_o = (cause != DROP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q  <= 1'b0;
      ack_q   <= 1'b0;
      sleep_q <= 1'b0;
      src_q   <= '0;
    end else begin
      sleep_q <= drop_o;
      if (drop_o) begin
        wake_q <= 1'b0;
        ack_q  <= 1'b0;
        src_q  <= '0;
      end else if (!wake_q) begin
        if (|hit) begin
          wake_q <= 1'b1;
          ack_q  <= 1'b0;
          src_q  <= hit;
        end
      end else if (clr_ok_i && !ack_q) begin
        ack_q <= 1'b1;
        src_q <= '0;
      end
    end
  end

  assign wake_o  = wake_q;
  assign ack_o   = ack_q;
  assign sleep_o = sleep_q;
  assign src_o   = src_q;
endmodule

// File: rtl/wake_sleep_seq.sv
module wake_sleep_seq
  import wss_pkg::*;
#(
  parameter int NW         = 4,
  parameter int WDT_CYCLES = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] wake_n_i,
  input  logic          clr_i,
  input  logic          sleep_i,
  input  logic          seq_sel_i,
  input  logic          rst1_int_i,
  input  logic          rst1_ext_i,
  input  logic          rst2_ext_i,
  output logic          wake_o,
  output logic          sleep_int_o,
  output logic [NW-1:0] wake_src_o,
  output logic          stby_vo1_o,
  output logic          sw_oe_o
);
  logic [NW-1:0] wake_n_s;
  logic [1:0]    hs_s;
  logic          clr_s, slp_s;
  logic          clr_ok, slp_rise, fire, drop, ack, wake_q, forced;

  wss_sync #(.W(NW), .STAGES(SYNC_STAGES), .RST_VAL({NW{1'b1}})) u_sync_wake (
    .clk(clk), .rst_n(rst_n), .d_i(wake_n_i), .q_o(wake_n_s)
  );

  wss_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_hs (
    .clk(clk), .rst_n(rst_n), .d_i({clr_i, sleep_i}), .q_o(hs_s)
  );

  assign clr_s  = hs_s[1];
  assign slp_s  = hs_s[0];
  assign forced = ~rst1_int_i & rst1_ext_i;

  wss_gate u_gate (
    .clk(clk), .rst_n(rst_n), .clr_s_i(clr_s), .slp_s_i(slp_s),
    .seq_sel_i(seq_sel_i), .rst1_ext_i(rst1_ext_i), .rst2_ext_i(rst2_ext_i),
    .clr_ok_o(clr_ok), .slp_rise_o(slp_rise)
  );

  wss_watchdog #(.LIMIT(WDT_CYCLES)) u_wdt (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_q), .ack_i(ack),
    .clr_ok_i(clr_ok), .drop_i(drop), .fire_o(fire)
  );

  wss_wake_latch #(.NW(NW)) u_latch (
    .clk(clk), .rst_n(rst_n), .wake_n_s_i(wake_n_s), .clr_ok_i(clr_ok),
    .slp_rise_i(slp_rise), .wdt_fire_i(fire), .force_i(forced),
    .wake_o(wake_q), .ack_o(ack), .drop_o(drop), .sleep_o(sleep_int_o),
    .src_o(wake_src_o)
  );

  // supply-source and clear-switch map
  assign wake_o     = wake_q;
  assign stby_vo1_o = wake_q & rst1_int_i;
  assign sw_oe_o    = wake_q & rst1_int_i & clr_s;
endmodule

// File: rtl/wake_sleep_seq_chk.sv
module wake_sleep_seq_chk #(
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst1_int_i,
  input logic          rst1_ext_i,
  input logic          wake_o,
  input logic          sleep_int_o,
  input logic [NW-1:0] wake_src_o,
  input logic          stby_vo1_o,
  input logic          sw_oe_o
);
  p_src_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_o |-> (wake_src_o == '0));

  p_src_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && wake_src_o != '0) |=> ((wake_src_o == $past(wake_src_o)) || (wake_src_o == '0)));

  // R5 and R7: every wake drop comes with an internal sleep pulse
  p_fall_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_o) |-> sleep_int_o);

  p_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst1_int_i && rst1_ext_i) |=> (sleep_int_o && !wake_o));

  p_sw_vo1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_oe_o |-> stby_vo1_o);

  p_vo1_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stby_vo1_o |-> wake_o);
endmodule

bind wake_sleep_seq wake_sleep_seq_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst1_int_i(rst1_int_i), .rst1_ext_i(rst1_ext_i),
  .wake_o(wake_o), .sleep_int_o(sleep_int_o), .wake_src_o(wake_src_o),
  .stby_vo1_o(stby_vo1_o), .sw_oe_o(sw_oe_o)
);

// File: tb/wake_sleep_seq_tb.sv
module wake_sleep_seq_tb;
  localparam int NW = 4;
  localparam int L  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NW-1:0] wk = '1;
  logic clr = 1'b0, slp = 1'b0, seq = 1'b0;
  logic r1i = 1'b1, r1e = 1'b1, r2e = 1'b1;

  logic          wake_o, sleep_int_o, stby_vo1_o, sw_oe_o;
  logic [NW-1:0] wake_src_o;

  wake_sleep_seq #(.NW(NW), .WDT_CYCLES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .wake_n_i(wk), .clr_i(clr), .sleep_i(slp),
    .seq_sel_i(seq), .rst1_int_i(r1i), .rst1_ext_i(r1e), .rst2_ext_i(r2e),
    .wake_o(wake_o), .sleep_int_o(sleep_int_o), .wake_src_o(wake_src_o),
    .stby_vo1_o(stby_vo1_o), .sw_oe_o(sw_oe_o)
  );

  // cycle model written from the requirements
  logic [NW-1:0] m_w1, m_w2, m_src;
  logic m_c1, m_c2, m_p1, m_p2, m_wake, m_ack, m_sleep, m_sprev;
  int   m_cnt;

  always @(posedge clk or negedge rst_n) begin
    logic sel, c_ok, s_ok, s_rise, frc, fire, drop;
    if (!rst_n) begin
      m_w1 <= '1; m_w2 <= '1; m_c1 <= 0; m_c2 <= 0; m_p1 <= 0; m_p2 <= 0;
      m_wake <= 0; m_ack <= 0; m_sleep <= 0; m_sprev <= 0; m_src <= '0; m_cnt <= 0;
    end else begin
      sel    = seq ? r2e : r1e;                 // R8
      c_ok   = m_c2 & sel;                      // R4
      s_ok   = m_p2 & sel & ~m_c2;              // R5
      s_rise = s_ok & ~m_sprev;
      frc    = ~r1i & r1e;                      // R10
      fire   = m_wake & ~m_ack & (m_cnt == L-1) & ~c_ok;  // R7, R11
      drop   = frc | (m_wake & (s_rise | fire));
      m_w1 <= wk; m_w2 <= m_w1; m_c1 <= clr; m_c2 <= m_c1; m_p1 <= slp; m_p2 <= m_p1;
      m_sprev <= s_ok;
      m_sleep <= drop;
      m_cnt   <= (!m_wake || m_ack || drop) ? 0 : m_cnt + 1;
      if (drop) begin
        m_wake <= 0; m_ack <= 0; m_src <= '0;
      end else if (!m_wake) begin
        if (~m_w2 != '0) begin m_wake <= 1; m_ack <= 0; m_src <= ~m_w2; end
      end else if (c_ok && !m_ack) begin
        m_ack <= 1; m_src <= '0;
      end
    end
  end

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1 reset";
  bit    done   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: wait for negedge, compare everything against the model
  task automatic tick();
    logic [31:0] a, e;
    @(negedge clk);
    a = {24'd0, wake_src_o, wake_o, sleep_int_o, stby_vo1_o, sw_oe_o};
    e = {24'd0, m_src, m_wake, m_sleep, m_wake & r1i, m_wake & r1i & m_c2};
    chk({phase, " model"}, a, e);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_wake();
    for (int i = 0; i < 10 && !wake_o; i++) tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    ticks(3);
    rst_n = 1'b1;
    tick();
    chk("R1 reset outputs", {wake_o, sleep_int_o, stby_vo1_o, sw_oe_o, wake_src_o}, '0);

    phase = "R2 wake latch";
    wk = 4'b1011; tick(); wk = '1; tick();
    chk("R2 latency", wake_o, 0);
    tick();
    chk("R2 wake set", wake_o, 1);
    chk("R2 source bit", wake_src_o, 4'b0100);
    chk("R9 vo1 source", {stby_vo1_o, sw_oe_o}, 2'b10);

    phase = "R3 frozen";
    wk = 4'b1110; ticks(3); wk = '1; ticks(2);
    chk("R3 source unchanged", wake_src_o, 4'b0100);

    phase = "R4 clear gating";
    r1e = 0; r1i = 0; clr = 1; ticks(4);
    chk("R4 clear blocked", wake_src_o, 4'b0100);
    chk("R9 battery source", stby_vo1_o, 0);
    r1e = 1; r1i = 1; tick();
    chk("R4 clear accepted", {wake_o, wake_src_o}, 5'b10000);
    chk("R9 switch driven", sw_oe_o, 1);

    phase = "R5 sleep";
    slp = 1; ticks(4);
    chk("R5 sleep ignored with clr", wake_o, 1);
    clr = 0; ticks(2);
    chk("R5 still awake", wake_o, 1);
    tick();
    chk("R5 wake dropped", {wake_o, sleep_int_o}, 2'b01);
    tick();
    chk("R5 sleep pulse one cycle", sleep_int_o, 0);
    slp = 0; ticks(3);

    phase = "R6 sleep first";
    wk = 4'b1110; ticks(3); wk = '1;
    chk("R6 awake", wake_o, 1);
    slp = 1; ticks(3);
    chk("R6 latch cleared", {wake_o, wake_src_o}, 5'b00000);
    slp = 0; ticks(3);

    phase = "R8 channel select";
    seq = 1; r2e = 0;
    wk = 4'b1101; ticks(3); wk = '1;
    clr = 1; ticks(4);
    chk("R8 channel 2 low blocks clear", wake_src_o, 4'b0010);
    r2e = 1; tick();
    chk("R8 channel 2 good", wake_src_o, 4'b0000);
    clr = 0; ticks(3); slp = 1; ticks(4);
    chk("R8 released", wake_o, 0);
    slp = 0; seq = 0; ticks(3);

    phase = "R7 watchdog";
    wk = 4'b0111; tick(); wk = '1;
    wait_wake();
    n = 0;
    while (wake_o && n < 4 * L) begin n++; tick(); end
    chk("R7 window length", n, L);
    chk("R7 expiry sleep", sleep_int_o, 1);
    ticks(3);

    phase = "R11 clear vs expiry";
    wk = 4'b1110; tick(); wk = '1;
    wait_wake();
    ticks(L - 3); clr = 1; ticks(3);
    chk("R11 clear wins", {wake_o, sleep_int_o, wake_src_o}, 6'b100000);
    ticks(2);
    chk("R11 stays awake", wake_o, 1);
    clr = 0; ticks(3); slp = 1; ticks(4); slp = 0; ticks(3);
    wk = 4'b1110; tick(); wk = '1;
    wait_wake();
    ticks(L - 2); clr = 1; ticks(3);
    chk("R11 late clear loses", wake_o, 0);
    clr = 0; ticks(3);

    phase = "R10 forced";
    r1i = 0; wk = 4'b0000; tick();
    chk("R10 forced sleep", {sleep_int_o, wake_o}, 2'b10);
    ticks(3);
    chk("R10 no latch", wake_o, 0);
    wk = '1; ticks(3); r1i = 1; ticks(3);

    phase = "R2/R4/R5/R7/R9/R10 random";
    for (int c = 0; c < 20000; c++) begin
      for (int b = 0; b < NW; b++) wk[b] = ($urandom % 60) != 0;
      if ($urandom % 30 == 0) clr = ~clr;
      if ($urandom % 30 == 0) slp = ~slp;
      if ($urandom % 500 == 0) seq = ~seq;
      if ($urandom % 150 == 0) {r1i, r1e} = 2'($urandom);
      else if ($urandom % 12 == 0) {r1i, r1e} = 2'b11;
      if ($urandom % 150 == 0) r2e = 1'($urandom);
      else if ($urandom % 12 == 0) r2e = 1'b1;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule